// File: doc/BRIEF.md
# Validated Register Read Front End

This block sits between a requester that reads interface registers and a bus engine that does the actual byte transfer. A request carries an interface address and a byte count. The block turns the address into an 8-bit bus register index, starts a read through a request/acknowledge pair, and checks the returned value. Some registers have bits that a healthy device always returns as zero. When one of those bits comes back set, the block waits a fixed back-off time and issues the whole read again. It gives up after a set number of attempts.

The bus engine returns bytes little-endian: byte 0 is in bits [7:0]. The block clears every byte above the requested count. It then returns either the value that passed the check or, once no attempts remain, the last value read together with an error bit. Only one request is handled at a time; `req_ready` is high only while the block is idle.

The controller has four states:
- IDLE: waits for `req_valid` and goes to ISSUE.
- ISSUE: holds `bus_rd_req` until `bus_rd_ack`. On the acknowledge it goes to REPLY if the check passes or if no attempts remain, and to BACKOFF otherwise.
- BACKOFF: counts `WAIT_CYCLES` cycles and then returns to ISSUE.
- REPLY: pulses `rsp_valid` for one cycle and returns to IDLE.

Top module: `tpmrd_validator`

## Requirements
- R1: Only bits [11:0] of `req_addr` choose the register. All higher address bits have no effect on `bus_reg` or on the check.
- R2: The 12-bit address maps to `bus_reg` as follows. All other addresses give their low 8 bits.

  | 12-bit address | `bus_reg` |
  |---|---|
  | 0x000 | 0x04 |
  | 0xFFF | 0x00 |
  | 0xF00 | 0x48 |
  | 0xF04 | 0x4C |

  `bus_len` equals the requested byte count.
- R3: `rsp_data` holds the returned bytes little-endian (byte 0 in bits [7:0]). Every byte at or above `req_len` reads zero, for `req_len` from 1 to 4.
- R4: After the byte trimming of R3, a read fails its check when the value overlaps the reserved-zero mask of its bus index:

  | Bus index | Register | Reserved-zero mask |
  |---|---|---|
  | 0x04 | access | 0x00000048 |
  | 0x08 | interrupt enable | 0x7FFFFF60 |
  | 0x14 | interface capability | 0x0FFFF000 |
  | 0x18 | status | 0x00000023 |
  | 0x30 | bus interface capability | 0x80000000 |

- R5: The check applies only to lengths 1, 2 and 4. A length of 3, or any index not listed in R4, always passes.
- R6: After a failed check with attempts left, the next bus read starts exactly `WAIT_CYCLES`+1 cycles after the failing acknowledge.
- R7: After `MAX_TRIES` failed attempts, the response has `rsp_err`=1 and carries the last trimmed value. No further bus read is made.
- R8: A passing read gives `rsp_err`=0 with the value that passed. `rsp_valid` is a single-cycle pulse. `bus_rd_req` stays high until acknowledged.
- R9: After reset, `req_ready`=1 and `bus_rd_req`=0 and `rsp_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read request, taken when req_ready is high |
| req_ready | output | 1 | Block is idle and can take a request |
| req_addr | input | ADDR_W | Interface register address |
| req_len | input | 3 | Byte count, 1 to 4 |
| bus_rd_req | output | 1 | Bus read request, held until acknowledged |
| bus_reg | output | 8 | Bus register index |
| bus_len | output | 3 | Bytes to read |
| bus_rd_ack | input | 1 | Bus read done, data valid |
| bus_rd_data | input | 32 | Bus read data, little-endian |
| rsp_valid | output | 1 | Response pulse |
| rsp_data | output | 32 | Validated or last value |
| rsp_err | output | 1 | Attempts exhausted on a failing value |

## Verification
The hardest path to reach is a run of failing reads that ends in either a late recovery or exhaustion. The bus model in the bench returns the value with the reserved bits forced on for a programmable number of attempts, then returns a clean value. Sweeping that count from zero to `MAX_TRIES`, across every remapped and masked register and every length, covers the following cases:
- recovery after one or more retries;
- the error exit;
- masks that trimming to 1 or 2 bytes cancels;
- the length-3 exemption.

The bench also measures the gap in cycles between attempts.

// File: rtl/tpmrd_pkg.sv
package tpmrd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_BACKOFF,
        ST_REPLY
    } rd_state_e;

    localparam int unsigned LOC_W = 12;

    localparam logic [LOC_W-1:0] A_ACCESS0 = 12'h000;
    localparam logic [LOC_W-1:0] A_LOCSEL  = 12'hFFF;
    localparam logic [LOC_W-1:0] A_IDENT   = 12'hF00;
    localparam logic [LOC_W-1:0] A_REVN    = 12'hF04;

    localparam logic [7:0] IX_LOCSEL = 8'h00;
    localparam logic [7:0] IX_ACCESS = 8'h04;
    localparam logic [7:0] IX_INTEN  = 8'h08;
    localparam logic [7:0] IX_CAPS   = 8'h14;
    localparam logic [7:0] IX_STAT   = 8'h18;
    localparam logic [7:0] IX_BCAPS  = 8'h30;
    localparam logic [7:0] IX_IDENT  = 8'h48;
    localparam logic [7:0] IX_REVN   = 8'h4C;

    localparam logic [31:0] RZ_ACCESS = 32'h0000_0048;
    localparam logic [31:0] RZ_INTEN  = 32'h7FFF_FF60;
    localparam logic [31:0] RZ_CAPS   = 32'h0FFF_F000;
    localparam logic [31:0] RZ_STAT   = 32'h0000_0023;
    localparam logic [31:0] RZ_BCAPS  = 32'h8000_0000;

endpackage

// File: rtl/tpmrd_remap.sv
module tpmrd_remap
    import tpmrd_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr_in,
    output logic [7:0]        idx_out
);
    logic [LOC_W-1:0] low_addr;

    assign low_addr = addr_in[LOC_W-1:0];

    always_comb begin
        unique case (low_addr)
            A_ACCESS0: idx_out = IX_ACCESS;
            A_LOCSEL:  idx_out = IX_LOCSEL;
            A_IDENT:   idx_out = IX_IDENT;
            A_REVN:    idx_out = IX_REVN;
            default:   idx_out = low_addr[7:0];
        endcase
    end
endmodule

// File: rtl/tpmrd_check.sv
module tpmrd_check
    import tpmrd_pkg::*;
#(
    parameter int unsigned NBYTES = 4
) (
    input  logic [7:0]          idx_in,
    input  logic [2:0]          len_in,
    input  logic [NBYTES*8-1:0] raw_in,
    output logic [NBYTES*8-1:0] value_out,
    output logic                ok_out
);
    logic [NBYTES*8-1:0] rz_mask;
    logic                sized;

    for (genvar b = 0; b < NBYTES; b++) begin : g_trim
        assign value_out[b*8 +: 8] = (32'(b) < 32'(len_in)) ? raw_in[b*8 +: 8] : 8'h00;
    end

    always_comb begin
        unique case (idx_in)
            IX_ACCESS: rz_mask = RZ_ACCESS;
            IX_INTEN:  rz_mask = RZ_INTEN;
            IX_CAPS:   rz_mask = RZ_CAPS;
            IX_STAT:   rz_mask = RZ_STAT;
            IX_BCAPS:  rz_mask = RZ_BCAPS;
            default:   rz_mask = '0;
        endcase
    end

    assign sized  = (len_in == 3'd1) || (len_in == 3'd2) || (len_in == 3'd4);
    assign ok_out = !sized || ((value_out & rz_mask) == '0);
endmodule

// File: rtl/tpmrd_validator.sv
module tpmrd_validator
    import tpmrd_pkg::*;
#(
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned MAX_TRIES   = 3,
    parameter int unsigned WAIT_CYCLES = 31250
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_len,
    output logic              bus_rd_req,
    output logic [7:0]        bus_reg,
    output logic [2:0]        bus_len,
    input  logic              bus_rd_ack,
    input  logic [31:0]       bus_rd_data,
    output logic              rsp_valid,
    output logic [31:0]       rsp_data,
    output logic              rsp_err
);
    localparam int unsigned TRY_W = $clog2(MAX_TRIES + 1);
    localparam int unsigned CNT_W = $clog2(WAIT_CYCLES + 1);
    localparam logic [TRY_W-1:0] LAST_TRY  = TRY_W'(MAX_TRIES - 1);
    localparam logic [CNT_W-1:0] WAIT_LOAD = CNT_W'(WAIT_CYCLES - 1);

    rd_state_e state_q, state_d;

    logic [7:0]       idx_map, idx_q;
    logic [2:0]       len_q;
    logic [TRY_W-1:0] tries_q;
    logic [CNT_W-1:0] wait_q;
    logic [31:0]      data_q, trimmed;
    logic             err_q, chk_ok, last_try;

    tpmrd_remap #(.ADDR_W(ADDR_W)) u_remap (
        .addr_in (req_addr),
        .idx_out (idx_map)
    );

    tpmrd_check #(.NBYTES(4)) u_check (
        .idx_in    (idx_q),
        .len_in    (len_q),
        .raw_in    (bus_rd_data),
        .value_out (trimmed),
        .ok_out    (chk_ok)
    );

    assign last_try = (tries_q == LAST_TRY);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid) state_d = ST_ISSUE;
            ST_ISSUE:   if (bus_rd_ack) state_d = (chk_ok || last_try) ? ST_REPLY : ST_BACKOFF;
            ST_BACKOFF: if (wait_q == '0) state_d = ST_ISSUE;
            ST_REPLY:   state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q   <= '0;
            len_q   <= '0;
            tries_q <= '0;
            wait_q  <= '0;
            data_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    idx_q   <= idx_map;
                    len_q   <= req_len;
                    tries_q <= '0;
                end
                ST_ISSUE: if (bus_rd_ack) begin
                    data_q  <= trimmed;
                    err_q   <= !chk_ok;
                    tries_q <= tries_q + 1'b1;
                    wait_q  <= WAIT_LOAD;
                end
                ST_BACKOFF: if (wait_q != '0) wait_q <= wait_q - 1'b1;
                default: ;
            endcase
        end
    end

    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        bus_rd_req = (state_q == ST_ISSUE);
        bus_reg    = idx_q;
        bus_len    = len_q;
        rsp_valid  = (state_q == ST_REPLY);
        rsp_data   = data_q;
        rsp_err    = err_q;
    end
endmodule

// File: rtl/tpmrd_validator_chk.sv
module tpmrd_validator_chk #(
    parameter int unsigned MAX_TRIES = 3
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [2:0]  req_len,
    input logic        bus_rd_req,
    input logic        bus_rd_ack,
    input logic [7:0]  bus_reg,
    input logic        rsp_valid,
    input logic [31:0] rsp_data
);
    int unsigned issued;
    logic [2:0]  len_cap;
    logic        req_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            issued   <= 0;
            len_cap  <= '0;
            req_prev <= 1'b0;
        end else begin
            req_prev <= bus_rd_req;
            if (req_valid && req_ready) begin
                issued  <= 0;
                len_cap <= req_len;
            end else if (bus_rd_req && !req_prev) begin
                issued <= issued + 1;
            end
        end
    end

    // R9
    reset_idle_chk: assert property (@(posedge clk) $rose(rst_n) |-> (req_ready && !bus_rd_req && !rsp_valid));

    // R8
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |=> !rsp_valid);

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (bus_rd_req && !bus_rd_ack) |=> bus_rd_req);

    // R2
    reg_stable_chk: assert property (@(posedge clk) disable iff (!rst_n) (bus_rd_req && !bus_rd_ack) |=> $stable(bus_reg));

    // R7
    try_limit_chk: assert property (@(posedge clk) disable iff (!rst_n) issued <= MAX_TRIES);

    // R3
    trim_one_chk: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && len_cap == 3'd1) |-> (rsp_data[31:8] == '0));

    // R3
    trim_two_chk: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && len_cap == 3'd2) |-> (rsp_data[31:16] == '0));
endmodule

bind tpmrd_validator tpmrd_validator_chk #(.MAX_TRIES(MAX_TRIES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_len    (req_len),
    .bus_rd_req (bus_rd_req),
    .bus_rd_ack (bus_rd_ack),
    .bus_reg    (bus_reg),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data)
);

// File: tb/tpmrd_validator_test.sv
module tpmrd_validator_test;
    localparam int TRIES = 3;
    localparam int WAITC = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_addr = '0;
    logic [2:0]  req_len = 3'd1;
    logic        bus_rd_req;
    logic [7:0]  bus_reg;
    logic [2:0]  bus_len;
    logic        bus_rd_ack = 1'b0;
    logic [31:0] bus_rd_data = '0;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        rsp_err;

    int checks = 0;
    int fails = 0;

    int          cyc = 0;
    int          reads = 0;
    int          n_bad = 0;
    int          last_ack = 0;
    int          gap_err = 0;
    logic [31:0] good_v, bad_v;
    logic [7:0]  seen_reg;
    logic [2:0]  seen_len;

    always #4 clk = ~clk;

    tpmrd_validator #(.ADDR_W(16), .MAX_TRIES(TRIES), .WAIT_CYCLES(WAITC)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .bus_rd_req(bus_rd_req),
        .bus_reg(bus_reg), .bus_len(bus_len), .bus_rd_ack(bus_rd_ack),
        .bus_rd_data(bus_rd_data), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rsp_err(rsp_err)
    );

    // bus model: acknowledges each request one negedge after seeing it
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (bus_rd_ack) begin
            bus_rd_ack <= 1'b0;
        end else if (bus_rd_req) begin
            if (reads > 0 && (cyc - last_ack) != WAITC + 1) gap_err <= gap_err + 1;
            bus_rd_ack  <= 1'b1;
            bus_rd_data <= (reads < n_bad) ? bad_v : good_v;
            seen_reg    <= bus_reg;
            seen_len    <= bus_len;
            last_ack    <= cyc;
            reads       <= reads + 1;
        end
    end

    function automatic logic [7:0] exp_idx(input logic [15:0] a);
        logic [11:0] l;
        l = a[11:0];
        case (l)
            12'h000: return 8'h04;
            12'hFFF: return 8'h00;
            12'hF00: return 8'h48;
            12'hF04: return 8'h4C;
            default: return l[7:0];
        endcase
    endfunction

    function automatic logic [31:0] exp_mask(input logic [7:0] ix);
        case (ix)
            8'h04: return 32'h0000_0048;
            8'h08: return 32'h7FFF_FF60;
            8'h14: return 32'h0FFF_F000;
            8'h18: return 32'h0000_0023;
            8'h30: return 32'h8000_0000;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] trim(input logic [31:0] v, input int n);
        logic [31:0] k;
        k = (n >= 4) ? 32'hFFFF_FFFF : ((32'h1 << (8 * n)) - 1);
        return v & k;
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run_vec(input logic [15:0] a, input int n, input int bad);
        logic [7:0]  ix;
        logic [31:0] m, gv, bv, exp_d;
        logic        fails_chk, exp_e;
        int          exp_reads, wd;
        ix = exp_idx(a);
        m  = exp_mask(ix);
        gv = ((32'h9E37_79B9 * (32'(a) + 32'(n) * 7 + 1)) ^ 32'h5A5A_A5A5) & ~m;
        bv = gv | m;
        fails_chk = ((trim(bv, n) & m) != 0) && (n == 1 || n == 2 || n == 4);
        if (!fails_chk) begin
            exp_reads = 1; exp_e = 1'b0;
            exp_d = trim((bad > 0) ? bv : gv, n);
        end else if (bad >= TRIES) begin
            exp_reads = TRIES; exp_e = 1'b1; exp_d = trim(bv, n);
        end else begin
            exp_reads = bad + 1; exp_e = 1'b0; exp_d = trim(gv, n);
        end

        @(negedge clk);
        good_v = gv; bad_v = bv; n_bad = bad; reads = 0; gap_err = 0;
        req_addr = a; req_len = 3'(n); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wd = 0;
        while (!rsp_valid && wd < 2000) begin
            @(negedge clk);
            wd++;
        end
        if (wd >= 2000) begin
            checks++; fails++;
            $display("FAIL R8 watchdog: actual no response expected response");
            return;
        end
        chk("R2", "bus_reg", 32'(seen_reg), 32'(ix));
        chk("R2", "bus_len", 32'(seen_len), 32'(n));
        chk("R3", "rsp_data", rsp_data, exp_d);
        chk(exp_e ? "R7" : "R8", "rsp_err", 32'(rsp_err), 32'(exp_e));
        chk("R6", "bus reads", 32'(reads), 32'(exp_reads));
        chk("R6", "retry gap errors", 32'(gap_err), 32'd0);
        @(negedge clk);
        chk("R8", "rsp_valid pulse", 32'(rsp_valid), 32'd0);
    endtask

    initial begin
        logic [15:0] addrs [11];
        addrs = '{16'h0000, 16'h0FFF, 16'h0F00, 16'h0F04, 16'h0008, 16'h0018,
                  16'h0014, 16'h0030, 16'h0024, 16'h2030, 16'hF000};
        repeat (3) @(negedge clk);
        chk("R9", "req_ready", 32'(req_ready), 32'd1);
        chk("R9", "bus_rd_req", 32'(bus_rd_req), 32'd0);
        chk("R9", "rsp_valid", 32'(rsp_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 addresses with high bits set (0x2030, 0xF000) share the low-bit behaviour
        // R4 R5 sweep all masked indices, lengths 1..4 and failure counts 0..TRIES
        for (int ai = 0; ai < 11; ai++)
            for (int n = 1; n <= 4; n++)
                for (int b = 0; b <= TRIES; b++)
                    run_vec(addrs[ai], n, b);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule